// File: doc/BRIEF.md
# Segment base-limit address translator

This block turns a logical address into a physical address using three segment register pairs: program, data and stack. Each pair holds a base and a length. A request names a segment and carries an address. The block selects the matching base and length and compares the offset with the length. If the offset is in range, the response is base plus offset. If it is out of range, the response is a fault.

There are two ways to name the segment. In select mode, a separate two-bit field names it and the low 24 bits of the address are the offset. In table mode, the top byte of the 32-bit address names it and the low 24 bits are the offset. The registers are loaded through a write port that takes an index, a base/length choice and a data word. Each request gets exactly one registered answer one clock later.

Top module: `seg_xlate`

## Requirements
- R1: After reset every base and length register is zero and both response flags are low, so any request made before programming faults.
- R2: A write with `cfg_we` high stores `cfg_wdata` in segment `cfg_idx` (0 program, 1 data, 2 stack). It goes to the length register when `cfg_len` is 1, keeping the low 25 bits, and to the base register when `cfg_len` is 0. A write with index 3 changes no segment.
- R3: In select mode (`req_mode` 0) the segment is `req_seg` and the offset is `req_addr[23:0]`. Bits 31..24 of the address have no effect.
- R4: In table mode (`req_mode` 1) the segment number is `req_addr[31:24]` and the offset is `req_addr[23:0]`. `req_seg` has no effect.
- R5: An accepted request returns base plus offset, taken modulo 2^32.
- R6: A request faults when its offset is greater than or equal to the segment length. Offset length-1 is accepted, and a length of 0 makes every offset fault.
- R7: A segment number of 3 or more faults, whichever mode named it.
- R8: A response appears in the cycle after `req_valid`. Exactly one of `rsp_ok` and `rsp_fault` is high in that cycle, and neither is high after a cycle without a request.
- R9: `rsp_paddr` is zero whenever `rsp_ok` is low.
- R10: A request made in the same cycle as a register write is translated with the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 2 | Segment index for the write |
| cfg_len | input | 1 | 1 writes length, 0 writes base |
| cfg_wdata | input | 32 | Write data |
| req_valid | input | 1 | Translation request |
| req_mode | input | 1 | 0 select mode, 1 table mode |
| req_seg | input | 2 | Segment in select mode |
| req_addr | input | 32 | Logical address |
| rsp_ok | output | 1 | Translation accepted |
| rsp_fault | output | 1 | Translation faulted |
| rsp_paddr | output | 32 | Physical address, valid with rsp_ok |

## Verification
The assertions assume that `req_valid` and `req_mode` are always known after reset. They also assume that a response is a function only of the request in the previous cycle, never of an older one. The stimulus keeps to this by driving every input on the falling edge and returning `req_valid` to zero between requests. The out-of-range segment checks depend only on the request fields. The range checks are left to the bench, which knows the programmed lengths.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
    localparam int DEF_PA_W  = 32;
    localparam int DEF_OFF_W = 24;
    localparam int DEF_NSEG  = 3;

    typedef enum logic {
        MODE_SELECT = 1'b0,
        MODE_TABLE  = 1'b1
    } seg_mode_e;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile #(
    parameter int PA_W  = 32,
    parameter int LEN_W = 25,
    parameter int NSEG  = 3,
    parameter int SEL_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [SEL_W-1:0]           idx,
    input  logic                       is_len,
    input  logic [PA_W-1:0]            wdata,
    output logic [NSEG-1:0][PA_W-1:0]  bases,
    output logic [NSEG-1:0][LEN_W-1:0] lens
);
    logic [NSEG-1:0][PA_W-1:0]  base_d, base_q;
    logic [NSEG-1:0][LEN_W-1:0] len_d,  len_q;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic hit;
        assign hit = we && (idx == SEL_W'(g));
        always_comb begin
            base_d[g] = base_q[g];
            len_d[g]  = len_q[g];
            if (hit && !is_len) base_d[g] = wdata;
            if (hit &&  is_len) len_d[g]  = wdata[LEN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
        end else begin
            base_q <= base_d;
            len_q  <= len_d;
        end
    end

    assign bases = base_q;
    assign lens  = len_q;
endmodule

// File: rtl/seg_decode.sv
module seg_decode #(
    parameter int PA_W  = 32,
    parameter int OFF_W = 24,
    parameter int NSEG  = 3,
    parameter int SEL_W = 2,
    localparam int SEGF_W = PA_W - OFF_W
) (
    input  logic              mode,
    input  logic [SEL_W-1:0]  seg,
    input  logic [PA_W-1:0]   addr,
    output logic [SEGF_W-1:0] seg_num,
    output logic              seg_bad,
    output logic [OFF_W-1:0]  offset
);
    import seg_xlate_pkg::*;

    always_comb begin
        offset = addr[OFF_W-1:0];
        if (seg_mode_e'(mode) == MODE_TABLE) seg_num = addr[PA_W-1:OFF_W];
        else                                 seg_num = SEGF_W'(seg);
        seg_bad = (seg_num >= SEGF_W'(NSEG));
    end
endmodule

// File: rtl/seg_check.sv
module seg_check #(
    parameter int PA_W   = 32,
    parameter int OFF_W  = 24,
    parameter int LEN_W  = 25,
    parameter int NSEG   = 3,
    parameter int SEGF_W = 8
) (
    input  logic [NSEG-1:0][PA_W-1:0]  bases,
    input  logic [NSEG-1:0][LEN_W-1:0] lens,
    input  logic [SEGF_W-1:0]          seg_num,
    input  logic                       seg_bad,
    input  logic [OFF_W-1:0]           offset,
    output logic                       fault,
    output logic [PA_W-1:0]            paddr
);
    logic [PA_W-1:0]  sel_base;
    logic [LEN_W-1:0] sel_len;

    always_comb begin
        sel_base = '0;
        sel_len  = '0;
        for (int i = 0; i < NSEG; i++) begin
            if (seg_num == SEGF_W'(i)) begin
                sel_base = bases[i];
                sel_len  = lens[i];
            end
        end
        fault = seg_bad || (LEN_W'(offset) >= sel_len);
        paddr = sel_base + PA_W'(offset);
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate #(
    parameter int PA_W  = seg_xlate_pkg::DEF_PA_W,
    parameter int OFF_W = seg_xlate_pkg::DEF_OFF_W,
    parameter int NSEG  = seg_xlate_pkg::DEF_NSEG,
    localparam int SEL_W  = $clog2(NSEG + 1),
    localparam int LEN_W  = OFF_W + 1,
    localparam int SEGF_W = PA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_idx,
    input  logic             cfg_len,
    input  logic [PA_W-1:0]  cfg_wdata,
    input  logic             req_valid,
    input  logic             req_mode,
    input  logic [SEL_W-1:0] req_seg,
    input  logic [PA_W-1:0]  req_addr,
    output logic             rsp_ok,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_paddr
);
    typedef struct packed {
        logic            ok;
        logic            fault;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    logic [NSEG-1:0][PA_W-1:0]  bases;
    logic [NSEG-1:0][LEN_W-1:0] lens;
    logic [SEGF_W-1:0]          seg_num;
    logic                       seg_bad;
    logic [OFF_W-1:0]           offset;
    logic                       chk_fault;
    logic [PA_W-1:0]            chk_paddr;
    rsp_t                       rsp_d, rsp_q;

    seg_regfile #(.PA_W(PA_W), .LEN_W(LEN_W), .NSEG(NSEG), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .idx(cfg_idx), .is_len(cfg_len),
        .wdata(cfg_wdata), .bases(bases), .lens(lens)
    );

    seg_decode #(.PA_W(PA_W), .OFF_W(OFF_W), .NSEG(NSEG), .SEL_W(SEL_W)) u_dec (
        .mode(req_mode), .seg(req_seg), .addr(req_addr),
        .seg_num(seg_num), .seg_bad(seg_bad), .offset(offset)
    );

    seg_check #(.PA_W(PA_W), .OFF_W(OFF_W), .LEN_W(LEN_W), .NSEG(NSEG), .SEGF_W(SEGF_W)) u_chk (
        .bases(bases), .lens(lens), .seg_num(seg_num), .seg_bad(seg_bad),
        .offset(offset), .fault(chk_fault), .paddr(chk_paddr)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.fault = chk_fault;
            rsp_d.ok    = !chk_fault;
            if (!chk_fault) rsp_d.paddr = chk_paddr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_ok    = rsp_q.ok;
    assign rsp_fault = rsp_q.fault;
    assign rsp_paddr = rsp_q.paddr;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int PA_W  = 32,
    parameter int OFF_W = 24,
    parameter int NSEG  = 3,
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_mode,
    input logic [SEL_W-1:0] req_seg,
    input logic [PA_W-1:0]  req_addr,
    input logic             rsp_ok,
    input logic             rsp_fault,
    input logic [PA_W-1:0]  rsp_paddr
);
    localparam int SEGF_W = PA_W - OFF_W;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ok && rsp_fault)); // R8
    AST_ANSWER_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_ok || rsp_fault)); // R8
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !(rsp_ok || rsp_fault)); // R8
    AST_PADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_ok |-> (rsp_paddr == '0)); // R9
    AST_SEL_BAD_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_mode && (int'(req_seg) >= NSEG)) |=> rsp_fault); // R7
    AST_TBL_BAD_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode && (int'(req_addr[PA_W-1:OFF_W]) >= NSEG)) |=> rsp_fault); // R7
endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W), .OFF_W(OFF_W), .NSEG(NSEG), .SEL_W(SEL_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_seg(req_seg), .req_addr(req_addr), .rsp_ok(rsp_ok),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic        cfg_len = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_mode = 1'b0;
    logic [1:0]  req_seg = '0;
    logic [31:0] req_addr = '0;
    logic        rsp_ok, rsp_fault;
    logic [31:0] rsp_paddr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    seg_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_len(cfg_len),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_mode(req_mode), .req_seg(req_seg),
        .req_addr(req_addr), .rsp_ok(rsp_ok), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    // {mode, seg, addr, exp_ok, exp_paddr}
    localparam int NV = 13;
    localparam logic [67:0] VEC [NV] = '{
        {1'b0, 2'd0, 32'h0000_0010, 1'b1, 32'h1000_0010},  // R3 R5
        {1'b0, 2'd0, 32'h0000_7FFF, 1'b1, 32'h1000_7FFF},  // R6 last in range
        {1'b0, 2'd0, 32'h0000_8000, 1'b0, 32'h0000_0000},  // R6 offset == length
        {1'b0, 2'd1, 32'hAB00_00FF, 1'b1, 32'h0004_F0FF},  // R3 top byte ignored
        {1'b0, 2'd1, 32'h0000_0100, 1'b0, 32'h0000_0000},  // R6
        {1'b0, 2'd2, 32'h0000_0200, 1'b1, 32'h0000_0100},  // R5 wrap
        {1'b0, 2'd3, 32'h0000_0000, 1'b0, 32'h0000_0000},  // R7
        {1'b1, 2'd2, 32'h0100_0020, 1'b1, 32'h0004_F020},  // R4 req_seg ignored
        {1'b1, 2'd3, 32'h0000_0005, 1'b1, 32'h1000_0005},  // R4
        {1'b1, 2'd0, 32'h02FF_FFFF, 1'b1, 32'h00FF_FEFF},  // R4 R5
        {1'b1, 2'd0, 32'h0300_0000, 1'b0, 32'h0000_0000},  // R7
        {1'b1, 2'd0, 32'h8000_0000, 1'b0, 32'h0000_0000},  // R7
        {1'b1, 2'd0, 32'h0100_0100, 1'b0, 32'h0000_0000}   // R6
    };

    task automatic check(input string req, input bit ok, input bit fault, input logic [31:0] pa,
                         input bit e_ok, input bit e_fault, input logic [31:0] e_pa);
        checks++;
        if (ok !== e_ok || fault !== e_fault || pa !== e_pa) begin
            errors++;
            $display("FAIL %s: ok=%0b fault=%0b paddr=%h expected ok=%0b fault=%0b paddr=%h",
                     req, ok, fault, pa, e_ok, e_fault, e_pa);
        end
    endtask

    task automatic cfg_write(input logic [1:0] idx, input bit is_len, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_len = is_len; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic request(input string req, input bit mode, input logic [1:0] seg,
                           input logic [31:0] addr, input bit e_ok, input logic [31:0] e_pa);
        @(negedge clk);
        req_valid = 1'b1; req_mode = mode; req_seg = seg; req_addr = addr;
        @(negedge clk);
        req_valid = 1'b0;
        check(req, rsp_ok, rsp_fault, rsp_paddr, e_ok, !e_ok, e_pa);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset outputs", rsp_ok, rsp_fault, rsp_paddr, 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;
        request("R1 unprogrammed segment faults", 1'b0, 2'd0, 32'h0000_0000, 1'b0, 32'h0);
        // R8: idle cycle gives no response
        @(negedge clk);
        check("R8 idle", rsp_ok, rsp_fault, rsp_paddr, 1'b0, 1'b0, 32'h0);

        // R2 programming
        cfg_write(2'd0, 1'b0, 32'h1000_0000);
        cfg_write(2'd0, 1'b1, 32'h0000_8000);
        cfg_write(2'd1, 1'b0, 32'h0004_F000);
        cfg_write(2'd1, 1'b1, 32'h0000_0100);
        cfg_write(2'd2, 1'b0, 32'hFFFF_FF00);
        cfg_write(2'd2, 1'b1, 32'h0100_0000);
        cfg_write(2'd3, 1'b0, 32'h5555_0000);
        cfg_write(2'd3, 1'b1, 32'h0000_0001);

        for (int i = 0; i < NV; i++) begin
            request("R3-vector table", VEC[i][67], VEC[i][66:65], VEC[i][64:33],
                    VEC[i][32], VEC[i][31:0]);
        end

        // R2: the index-3 writes left segment 0 intact
        request("R2 index 3 ignored", 1'b0, 2'd0, 32'h0000_0001, 1'b1, 32'h1000_0001);

        // R10: write length 0 to segment 0 and request it in the same cycle
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'd0; cfg_len = 1'b1; cfg_wdata = 32'h0;
        req_valid = 1'b1; req_mode = 1'b0; req_seg = 2'd0; req_addr = 32'h0000_0010;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        check("R10 old values used", rsp_ok, rsp_fault, rsp_paddr, 1'b1, 1'b0, 32'h1000_0010);
        request("R6 zero length faults", 1'b0, 2'd0, 32'h0000_0000, 1'b0, 32'h0);

        // R8 back-to-back requests
        @(negedge clk);
        req_valid = 1'b1; req_mode = 1'b0; req_seg = 2'd1; req_addr = 32'h0000_0001;
        @(negedge clk);
        check("R8 first of pair", rsp_ok, rsp_fault, rsp_paddr, 1'b1, 1'b0, 32'h0004_F001);
        req_seg = 2'd1; req_addr = 32'h0000_0200;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 second of pair", rsp_ok, rsp_fault, rsp_paddr, 1'b0, 1'b1, 32'h0);
        @(negedge clk);
        check("R9 quiet after pair", rsp_ok, rsp_fault, rsp_paddr, 1'b0, 1'b0, 32'h0);

        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: expected=done actual=hung");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule